// File: doc/BRIEF.md
# Four-Level Interrupt Priority Arbiter

This block decides which of five interrupt sources of a small 8-bit microcontroller is presented to the CPU. The sources are external input 0, timer 0 overflow, external input 1, timer 1 overflow and the serial port. Each source takes a 2-bit priority level from two special-function registers. One register supplies the level's least significant bit and the other supplies its most significant bit. This gives four nesting levels.

Software writes the priority registers a whole byte at a time. The low register can also be written one bit at a time. Every cycle the block looks at each source's pending and enable inputs and compares the source's level with the level currently in service. It registers a request and a vector index for the CPU. When the CPU acknowledges a request, the granted level is pushed onto an in-service stack. A return-from-interrupt pulse pops the most recent level off that stack, which restores the level of the interrupted handler.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset both priority registers read 0x00, `irq_req` is 0 and `svc_active` is 0.
- R2: A byte write to address 0xB8 stores bits 4..0 into the low register. A byte write to address 0xB7 stores bits 4..0 into the high register. Reads of either register return 0 in bits 7..5. Reads of any other address return 0x00.
- R3: A bit write to address 0xB8 with bit select 0..4 changes only that bit of the low register. A bit write to address 0xB7, or a bit write with bit select 5..7, changes nothing.
- R4: A source's level is {high bit, low bit}, where 3 is the highest level. The bit position in each register is the vector index: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial port. The eligible source with the highest level wins, whatever its index.
- R5: Among eligible sources at the same level, the lowest vector index wins.
- R6: A source is eligible only when both its pending bit and its enable bit are 1.
- R7: `irq_req` and `irq_vec` are registered and appear in the cycle after the inputs that cause them. While the request is raised and the granted source stays pending and enabled, `irq_vec` holds its value, even if a higher-level source arrives. If the granted source stops being pending or enabled, the request drops at the next edge.
- R8: `cpu_ack` asserted while `irq_req` is 1 pushes the granted level. In the next cycle `svc_active` is 1, `svc_lvl` shows that level, and `irq_req` is 0.
- R9: While a handler is in service, only sources at a strictly higher level than `svc_lvl` are granted. A source at an equal or lower level waits.
- R10: `reti` pops the in-service stack and restores the previous level, or the idle state when the stack empties. `reti` with an empty stack has no effect.
- R11: Handlers nest four deep, one per level, and unwind in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wdata | input | 8 | Byte write data |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_bit_wr | input | 1 | Single-bit write strobe |
| sfr_bit_sel | input | 3 | Bit position for a single-bit write |
| sfr_bit_val | input | 1 | Value for a single-bit write |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| irq_pend | input | 5 | Pending flag per source |
| irq_en | input | 5 | Enable per source |
| cpu_ack | input | 1 | CPU accepts the current request |
| reti | input | 1 | Return from the active handler |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 3 | Vector index of the requested source |
| svc_active | output | 1 | At least one handler is in service |
| svc_lvl | output | 2 | Level of the innermost handler in service |

## Verification
The hardest state to reach is a full in-service stack, with four handlers nested at levels 0, 1, 2 and 3. The bench gets there by giving four sources distinct levels and raising them one at a time in ascending level order. It acknowledges each request as it appears, so every new source outranks the handler below it. It then checks that a lowest-level source stays blocked and unwinds the stack one `reti` at a time. A second directed sequence holds a request unacknowledged while a higher-level source arrives, which is the only way to observe that the vector holds its value.

// File: rtl/irq_prio_pkg.sv
// Package: shared constants for the interrupt priority arbiter.
// Assumes an 8-bit register space and five interrupt sources.
package irq_prio_pkg;
    localparam int unsigned NUM_SRC   = 5;
    localparam int unsigned LEVEL_W   = 2;
    localparam int unsigned REG_DW    = 8;
    localparam int unsigned REG_AW    = 8;
    localparam logic [7:0]  PRIO_LO_ADDR = 8'hB8;
    localparam logic [7:0]  PRIO_HI_ADDR = 8'hB7;
endpackage

// File: rtl/irq_prio_regs.sv
// Module: priority register pair.
// What it does: holds the low-bit and high-bit priority registers. It accepts
// byte writes to both registers and single-bit writes to the low register
// only. It returns zero in reserved bits and for unknown addresses.
// Assumes: a byte write and a bit write in the same cycle are resolved in
// favour of the byte write.
module irq_prio_regs #(
    parameter int unsigned NSRC    = 5,
    parameter int unsigned DW      = 8,
    parameter int unsigned AW      = 8,
    parameter logic [AW-1:0] LO_ADDR = 8'hB8,
    parameter logic [AW-1:0] HI_ADDR = 8'hB7,
    localparam int unsigned BSEL_W = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              bit_wr_en,
    input  logic [BSEL_W-1:0] bit_sel,
    input  logic              bit_val,
    output logic [DW-1:0]     rdata,
    output logic [NSRC-1:0]   prio_lo,
    output logic [NSRC-1:0]   prio_hi
);

    logic [NSRC-1:0] lo_bit_nxt;

    // Low register image after a possible single-bit write.
    always_comb begin
        lo_bit_nxt = prio_lo;
        for (int i = 0; i < NSRC; i++) begin
            if (bit_sel == BSEL_W'(i)) lo_bit_nxt[i] = bit_val;
        end
    end

    // Register update: byte writes first, then bit writes to the low register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_lo <= '0;
            prio_hi <= '0;
        end else if (wr_en) begin
            if (addr == LO_ADDR) prio_lo <= wdata[NSRC-1:0];
            if (addr == HI_ADDR) prio_hi <= wdata[NSRC-1:0];
        end else if (bit_wr_en && addr == LO_ADDR) begin
            prio_lo <= lo_bit_nxt;
        end
    end

    // Read mux with zero-filled reserved bits.
    always_comb begin
        rdata = '0;
        if (addr == LO_ADDR) rdata[NSRC-1:0] = prio_lo;
        if (addr == HI_ADDR) rdata[NSRC-1:0] = prio_hi;
    end

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:NSRC] == '0);

    p_hi_bitwr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_en && !wr_en && addr == HI_ADDR) |=> $stable(prio_hi));

endmodule

// File: rtl/irq_prio_select.sv
// Module: combinational winner selection.
// What it does: forms each source's level from the register pair. It keeps
// the sources that are pending, enabled and strictly above the in-service
// level. It picks the highest level, and the lowest index breaks a tie.
// Assumes: cur_lvl is meaningful only when cur_valid is 1.
module irq_prio_select #(
    parameter int unsigned NSRC  = 5,
    parameter int unsigned LVL_W = 2,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  prio_lo,
    input  logic [NSRC-1:0]  prio_hi,
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  en,
    input  logic             cur_valid,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             cand_valid,
    output logic [IDX_W-1:0] cand_idx,
    output logic [LVL_W-1:0] cand_lvl
);

    logic [LVL_W-1:0] src_lvl [NSRC];
    logic [NSRC-1:0]  elig;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Level per source and its eligibility against the in-service level.
        always_comb begin
            src_lvl[g] = LVL_W'({prio_hi[g], prio_lo[g]});
            elig[g]    = pend[g] && en[g] && (!cur_valid || (src_lvl[g] > cur_lvl));
        end
    end

    // Scan from the highest index down so that a lower index wins a tie.
    always_comb begin
        cand_valid = 1'b0;
        cand_idx   = '0;
        cand_lvl   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i] && (!cand_valid || src_lvl[i] >= cand_lvl)) begin
                cand_valid = 1'b1;
                cand_idx   = IDX_W'(i);
                cand_lvl   = src_lvl[i];
            end
        end
    end

endmodule

// File: rtl/irq_svc_stack.sv
// Module: in-service level stack.
// What it does: records the level of each handler entered and exposes the
// innermost one. In the same cycle a pop is applied before a push.
// Assumes: pushed levels strictly increase, so DEPTH equals the number of
// levels and the stack cannot overflow.
module irq_svc_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LVL_W = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic             top_valid,
    output logic [LVL_W-1:0] top_lvl
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_popped;
    logic             push_ok;
    logic [LVL_W-1:0] mem [DEPTH];

    // Depth after an optional pop, and whether a push fits.
    always_comb begin
        cnt_popped = (pop && cnt != '0) ? cnt - 1'b1 : cnt;
        push_ok    = push && (cnt_popped < CNT_W'(DEPTH));
    end

    // Depth counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (push_ok) cnt <= cnt_popped + 1'b1;
        else              cnt <= cnt_popped;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // One slot is written when a push lands at its position.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   mem[g] <= '0;
            else if (push_ok && cnt_popped == CNT_W'(g))  mem[g] <= push_lvl;
        end
    end

    // Expose the innermost entry.
    always_comb begin
        top_valid = (cnt != '0);
        top_lvl   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CNT_W'(i + 1)) top_lvl = mem[i];
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt < CNT_W'(DEPTH)));

    p_push_above_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && top_valid) |-> (push_lvl > top_lvl));

    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !top_valid) |=> !top_valid);

endmodule

// File: rtl/irq_prio_arbiter.sv
// Module: four-level interrupt priority arbiter (top).
// What it does: ties the priority registers, the winner selection and the
// in-service stack together. It registers one decision per machine cycle
// and holds a raised request until the CPU acknowledges it or the source
// withdraws.
// Assumes: cpu_ack is asserted only for one cycle per accepted request, and
// reti is asserted once per handler exit.
module irq_prio_arbiter #(
    parameter int unsigned NSRC  = irq_prio_pkg::NUM_SRC,
    parameter int unsigned LVL_W = irq_prio_pkg::LEVEL_W,
    parameter int unsigned DW    = irq_prio_pkg::REG_DW,
    parameter int unsigned AW    = irq_prio_pkg::REG_AW,
    localparam int unsigned IDX_W  = $clog2(NSRC),
    localparam int unsigned BSEL_W = $clog2(DW),
    localparam int unsigned DEPTH  = 1 << LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     sfr_addr,
    input  logic [DW-1:0]     sfr_wdata,
    input  logic              sfr_wr,
    input  logic              sfr_bit_wr,
    input  logic [BSEL_W-1:0] sfr_bit_sel,
    input  logic              sfr_bit_val,
    output logic [DW-1:0]     sfr_rdata,
    input  logic [NSRC-1:0]   irq_pend,
    input  logic [NSRC-1:0]   irq_en,
    input  logic              cpu_ack,
    input  logic              reti,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_vec,
    output logic              svc_active,
    output logic [LVL_W-1:0]  svc_lvl
);

    logic [NSRC-1:0]  prio_lo;
    logic [NSRC-1:0]  prio_hi;
    logic             cand_valid;
    logic [IDX_W-1:0] cand_idx;
    logic [LVL_W-1:0] cand_lvl;
    logic             req_q;
    logic [IDX_W-1:0] vec_q;
    logic [LVL_W-1:0] lvl_q;
    logic             held_live;
    logic             take;

    irq_prio_regs #(
        .NSRC(NSRC), .DW(DW), .AW(AW),
        .LO_ADDR(AW'(irq_prio_pkg::PRIO_LO_ADDR)),
        .HI_ADDR(AW'(irq_prio_pkg::PRIO_HI_ADDR))
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wdata(sfr_wdata),
        .wr_en(sfr_wr), .bit_wr_en(sfr_bit_wr), .bit_sel(sfr_bit_sel),
        .bit_val(sfr_bit_val), .rdata(sfr_rdata),
        .prio_lo(prio_lo), .prio_hi(prio_hi)
    );

    irq_prio_select #(.NSRC(NSRC), .LVL_W(LVL_W)) u_select (
        .prio_lo(prio_lo), .prio_hi(prio_hi), .pend(irq_pend), .en(irq_en),
        .cur_valid(svc_active), .cur_lvl(svc_lvl),
        .cand_valid(cand_valid), .cand_idx(cand_idx), .cand_lvl(cand_lvl)
    );

    irq_svc_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(lvl_q), .pop(reti),
        .top_valid(svc_active), .top_lvl(svc_lvl)
    );

    // Is the source behind the raised request still pending and enabled?
    always_comb begin
        held_live = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (vec_q == IDX_W'(i)) held_live = irq_pend[i] && irq_en[i];
        end
        take = req_q && cpu_ack;
    end

    // Registered decision: accept, hold, withdraw or re-arbitrate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= '0;
            lvl_q <= '0;
        end else if (take) begin
            req_q <= 1'b0;
        end else if (req_q) begin
            req_q <= held_live;
        end else begin
            req_q <= cand_valid;
            vec_q <= cand_idx;
            lvl_q <= cand_lvl;
        end
    end

    assign irq_req = req_q;
    assign irq_vec = vec_q;

    p_vec_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !cpu_ack && held_live) |=> (irq_req && $stable(irq_vec)));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cpu_ack) |=> (!irq_req && svc_active));

    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec < IDX_W'(NSRC)));

    p_ack_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cpu_ack && !reti) |=> (svc_lvl == $past(lvl_q)));

endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic       sfr_wr = 1'b0;
    logic       sfr_bit_wr = 1'b0;
    logic [2:0] sfr_bit_sel = '0;
    logic       sfr_bit_val = 1'b0;
    logic [7:0] sfr_rdata;
    logic [4:0] irq_pend = '0;
    logic [4:0] irq_en = '0;
    logic       cpu_ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic       svc_active;
    logic [1:0] svc_lvl;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_wr(sfr_wr), .sfr_bit_wr(sfr_bit_wr), .sfr_bit_sel(sfr_bit_sel),
        .sfr_bit_val(sfr_bit_val), .sfr_rdata(sfr_rdata),
        .irq_pend(irq_pend), .irq_en(irq_en), .cpu_ack(cpu_ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec),
        .svc_active(svc_active), .svc_lvl(svc_lvl)
    );

    // Vector fields: {low reg, high reg, pend, en, expected req, expected vec}
    localparam int NV = 10;
    localparam logic [29:0] VECS [NV] = '{
        {8'h00, 8'h00, 5'h1F, 5'h1F, 1'b1, 3'd0},
        {8'h00, 8'h00, 5'h1E, 5'h1F, 1'b1, 3'd1},
        {8'h00, 8'h00, 5'h1F, 5'h06, 1'b1, 3'd1},
        {8'h10, 8'h10, 5'h1F, 5'h1F, 1'b1, 3'd4},
        {8'h08, 8'h04, 5'h1F, 5'h1F, 1'b1, 3'd2},
        {8'h0C, 8'h00, 5'h1F, 5'h1F, 1'b1, 3'd2},
        {8'h00, 8'h00, 5'h00, 5'h1F, 1'b0, 3'd0},
        {8'h00, 8'h00, 5'h1F, 5'h00, 1'b0, 3'd0},
        {8'h1F, 8'h1F, 5'h18, 5'h1F, 1'b1, 3'd3},
        {8'h01, 8'h00, 5'h1F, 5'h1E, 1'b1, 3'd1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        step();
        sfr_wr = 1'b0;
    endtask

    task automatic wr_bit(input logic [7:0] a, input logic [2:0] s, input logic v);
        sfr_addr = a; sfr_bit_sel = s; sfr_bit_val = v; sfr_bit_wr = 1'b1;
        step();
        sfr_bit_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    // Wait for a request, check its vector, acknowledge, check the pushed level.
    task automatic grant(input string tag, input int exp_vec, input int exp_lvl);
        for (int k = 0; k < 8 && !irq_req; k++) step();
        chk({tag, " req"}, irq_req, 1);
        chk({tag, " vec"}, irq_vec, exp_vec);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        chk({tag, " lvl"}, svc_lvl, exp_lvl);
        chk({tag, " req drop"}, irq_req, 0);
    endtask

    task automatic do_reti();
        reti = 1'b1;
        step();
        reti = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd(8'hB8, d); chk("R1 low reg", d, 8'h00);
        rd(8'hB7, d); chk("R1 high reg", d, 8'h00);
        chk("R1 req", irq_req, 0);
        chk("R1 active", svc_active, 0);

        // R2 byte writes and reserved bits
        wr_byte(8'hB8, 8'hFF);
        rd(8'hB8, d); chk("R2 low byte", d, 8'h1F);
        wr_byte(8'hB7, 8'hE5);
        rd(8'hB7, d); chk("R2 high byte", d, 8'h05);
        rd(8'h80, d); chk("R2 other addr", d, 8'h00);

        // R3 bit writes
        wr_bit(8'hB8, 3'd2, 1'b0);
        rd(8'hB8, d); chk("R3 low bit clear", d, 8'h1B);
        wr_bit(8'hB7, 3'd1, 1'b1);
        rd(8'hB7, d); chk("R3 high bit ignored", d, 8'h05);
        wr_bit(8'hB8, 3'd6, 1'b1);
        rd(8'hB8, d); chk("R3 reserved bit ignored", d, 8'h1B);

        // R4 R5 R6 vector table, stack empty
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VECS[i];
            irq_pend = '0;
            wr_byte(8'hB8, v[29:22]);
            wr_byte(8'hB7, v[21:14]);
            irq_pend = v[13:9];
            irq_en   = v[8:4];
            step();
            chk($sformatf("R4/R5/R6 vec%0d req", i), irq_req, int'(v[3]));
            if (v[3]) chk($sformatf("R4/R5/R6 vec%0d idx", i), irq_vec, int'(v[2:0]));
        end

        // R7 latency and hold; serial at level 3, external 0 at level 0
        irq_pend = '0;
        wr_byte(8'hB8, 8'h10);
        wr_byte(8'hB7, 8'h10);
        irq_en = 5'h1F;
        irq_pend = 5'h01;
        #1 chk("R7 no same-cycle req", irq_req, 0);
        step();
        chk("R7 req next cycle", irq_req, 1);
        chk("R7 vec", irq_vec, 0);
        irq_pend = 5'h11;
        step();
        chk("R7 held req", irq_req, 1);
        chk("R7 held vec", irq_vec, 0);

        // R8 acknowledge pushes level 0
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        chk("R8 req cleared", irq_req, 0);
        chk("R8 active", svc_active, 1);
        chk("R8 level", svc_lvl, 0);

        // R9 higher level preempts, equal and lower wait
        step();
        chk("R9 preempt req", irq_req, 1);
        chk("R9 preempt vec", irq_vec, 4);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        chk("R9 nested level", svc_lvl, 3);
        irq_pend = 5'h01;
        step(); step();
        chk("R9 lower blocked", irq_req, 0);
        irq_pend = 5'h11;
        step(); step();
        chk("R9 equal blocked", irq_req, 0);

        // R10 return restores previous level, then idle
        irq_pend = 5'h01;
        do_reti();
        chk("R10 pop level", svc_lvl, 0);
        chk("R10 pop active", svc_active, 1);
        step();
        chk("R9 equal level 0 blocked", irq_req, 0);
        do_reti();
        chk("R10 empty", svc_active, 0);
        step();
        chk("R10 idle grants level 0", irq_req, 1);
        chk("R10 idle vec", irq_vec, 0);
        irq_pend = '0;
        step();
        chk("R7 withdraw drops req", irq_req, 0);
        do_reti();
        chk("R10 pop on empty ignored", svc_active, 0);
        irq_pend = 5'h01;
        step();
        chk("R10 stack intact after empty pop", irq_req, 1);
        irq_pend = '0;
        step();

        // R11 four-deep nesting: ext0=0, tim0=1, ext1=2, tim1=3, serial=0
        wr_byte(8'hB8, 8'h0A);
        wr_byte(8'hB7, 8'h0C);
        irq_pend = 5'h01; grant("R11 depth1", 0, 0);
        irq_pend = 5'h03; grant("R11 depth2", 1, 1);
        irq_pend = 5'h07; grant("R11 depth3", 2, 2);
        irq_pend = 5'h0F; grant("R11 depth4", 3, 3);
        irq_pend = 5'h1F;
        step(); step();
        chk("R11 full stack blocks level 0", irq_req, 0);
        irq_pend = '0;
        do_reti(); chk("R11 unwind to 2", svc_lvl, 2);
        do_reti(); chk("R11 unwind to 1", svc_lvl, 1);
        do_reti(); chk("R11 unwind to 0", svc_lvl, 0);
        do_reti(); chk("R11 unwind empty", svc_active, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule